// File: doc/BRIEF.md
# Reset, Idle and Power-Down Sequencer

This block decides when an 8-bit controller core may run. It sits between the board pins and the core. It accepts a reset only after the reset pin has stayed high long enough. It parks the core in one of two low-power states when software asks for one. It brings the core back on an interrupt or a reset. When the strobe pins are held a certain way during reset, it latches an in-circuit test mode in which an external emulator drives the board.

In the light low-power state the oscillator keeps running and only the core halts. In the deep state the oscillator stops. A pending wake source restarts the oscillator, and a stabilisation counter must then expire before anything counts again. A deep-state exit through an external interrupt completes only when the interrupt pin returns high. During both low-power states the address-latch and program-read strobes are forced to fixed levels. In test mode the multiplexed bus port floats and the other pins fall back to weak pull-ups.

Top module: `pmu_seq`

## Requirements
- R1: A reset is accepted only after `rst_pin` has been sampled high on RST_CYC consecutive clock edges (default 24, two machine cycles of 12 clocks) while the oscillator runs and is stable. Acceptance raises `sfr_clr` for exactly one cycle, starting on the clock after the last of those edges. A shorter high pulse has no effect.
- R2: After `arst_n` the block is in reset: `core_run`=0, `osc_en`=1, `bus_float`=0, `sfr_clr`=0. Once `rst_pin` is low and the oscillator is stable, the core runs from the next clock.
- R3: Test mode is armed while in reset when `rst_pin` is high, `ale_pin` is low and `psen_pin` is high. Arming is lost if `ale_pin` rises. Test mode is entered when reset ends with the block armed and `ale_pin` still low. It then drives `bus_float`=1, `weak_pull`=1 and `core_run`=0. Any other case ends reset in the run state.
- R4: Test mode is left only through an accepted reset. Idle and power-down requests made in test mode are ignored, so both request bits read 0.
- R5: A one-cycle pulse on `idle_set` or `pd_set` sets the matching request bit (`idle_bit`, `pd_bit`) only while the core runs. The mode is entered on the clock after the bit appears. If both bits are set, power-down wins and the idle bit is discarded.
- R6: In idle, `core_run`=0, `osc_en`=1 and `strobe_hold_hi`=1. A high `irq_pend` returns the core to run on the next clock and clears `idle_bit`.
- R7: In power-down, `osc_en`=0, `strobe_hold_lo`=1 and `core_run`=0. A low level on an `ext_int_n` line whose `ext_lvl_en` bit is 0 has no effect.
- R8: A low level on an enabled `ext_int_n` line (active low) during power-down restarts the oscillator while the core stays halted. The core resumes only after the line returns high. This exit clears `pd_bit` and gives no `sfr_clr` pulse.
- R9: The stabilisation counter needs STAB_CYC (default 64) clocks of running oscillator. A wake line sampled low on N edges and then high completes the exit when N is at least STAB_CYC+1. Otherwise the oscillator stops again and the block stays in power-down.
- R10: A high `rst_pin` during power-down also restarts the oscillator. After stabilisation and RST_CYC more edges the reset is accepted, with one `sfr_clr` pulse and both request bits cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin | input | 1 | Reset pin level, active high |
| ale_pin | input | 1 | Address-latch strobe pin level, sampled during reset |
| psen_pin | input | 1 | Program-read strobe pin level, sampled during reset |
| ext_int_n | input | NINT | External interrupt lines, active low |
| ext_lvl_en | input | NINT | Per line: enabled and level-triggered |
| irq_pend | input | 1 | Some enabled interrupt is pending |
| idle_set | input | 1 | Software pulse requesting idle |
| pd_set | input | 1 | Software pulse requesting power-down |
| core_run | output | 1 | Core may execute |
| osc_en | output | 1 | Oscillator enable |
| sfr_clr | output | 1 | One-cycle special-register clear strobe |
| strobe_hold_hi | output | 1 | Force both strobe pins high |
| strobe_hold_lo | output | 1 | Force both strobe pins low |
| weak_pull | output | 1 | Non-bus ports and strobes weakly pulled high |
| bus_float | output | 1 | Multiplexed bus port floats |
| idle_bit | output | 1 | Idle request bit |
| pd_bit | output | 1 | Power-down request bit |

## Verification
The hardest case to reach is the edge of the stabilisation window during a deep-state wake. The wake line must be held low for exactly STAB_CYC and STAB_CYC+1 sampled edges, counted from the clock that first sees it low, after the counter has been cleared by a full stopped cycle. The stimulus first parks the block in power-down and waits a few clocks. It then drops the line and releases it after a computed number of edges. Random abort lengths shorter than the window, random reset-pulse widths around RST_CYC and random idle dwell times add to these directed boundaries.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  typedef enum logic [2:0] {
    S_RST    = 3'd0,
    S_RUN    = 3'd1,
    S_IDLE   = 3'd2,
    S_PDSTOP = 3'd3,
    S_PDWAKE = 3'd4,
    S_TEST   = 3'd5
  } pmu_state_e;
endpackage

// File: rtl/pmu_rst_qual.sv
module pmu_rst_qual #(
  parameter int RST_CYC = 24
) (
  input  logic clk,
  input  logic arst_n,
  input  logic rst_pin_i,
  input  logic osc_ok_i,
  output logic accept_o
);
  localparam int W = $clog2(RST_CYC + 1);
  localparam logic [W-1:0] FULL = W'(RST_CYC);
  localparam logic [W-1:0] LAST = W'(RST_CYC - 1);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!rst_pin_i || !osc_ok_i) cnt_d = '0;
    else if (cnt_q != FULL)      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign accept_o = rst_pin_i && osc_ok_i && (cnt_q == LAST);

  p_accept_prior_high_r1: assert property (@(posedge clk) disable iff (!arst_n)
    accept_o |-> $past(rst_pin_i));
  p_accept_single_r1: assert property (@(posedge clk) disable iff (!arst_n)
    accept_o |=> !accept_o);
endmodule

// File: rtl/pmu_stab_cnt.sv
module pmu_stab_cnt #(
  parameter int STAB_CYC = 64
) (
  input  logic clk,
  input  logic arst_n,
  input  logic osc_en_i,
  output logic done_o
);
  localparam int W = $clog2(STAB_CYC + 1);
  localparam logic [W-1:0] TOP = W'(STAB_CYC);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!osc_en_i)        cnt_d = '0;
    else if (cnt_q != TOP) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == TOP);

  p_stop_clears_r9: assert property (@(posedge clk) disable iff (!arst_n)
    !osc_en_i |=> !done_o);
endmodule

// File: rtl/pmu_test_arm.sv
module pmu_test_arm (
  input  logic clk,
  input  logic arst_n,
  input  logic in_rst_i,
  input  logic rst_pin_i,
  input  logic ale_i,
  input  logic psen_i,
  output logic arm_o
);
  logic arm_q, arm_d;

  always_comb begin
    arm_d = arm_q;
    if (!in_rst_i)      arm_d = 1'b0;
    else if (rst_pin_i) arm_d = arm_q ? !ale_i : (!ale_i && psen_i);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) arm_q <= 1'b0;
    else         arm_q <= arm_d;
  end

  assign arm_o = arm_q;

  p_arm_needs_psen_r3: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(arm_o) |-> $past(psen_i) && !$past(ale_i));
endmodule

// File: rtl/pmu_seq.sv
module pmu_seq
  import pmu_pkg::*;
#(
  parameter int MC_CLKS  = 12,
  parameter int RST_MC   = 2,
  parameter int STAB_CYC = 64,
  parameter int NINT     = 2
) (
  input  logic            clk,
  input  logic            arst_n,
  input  logic            rst_pin,
  input  logic            ale_pin,
  input  logic            psen_pin,
  input  logic [NINT-1:0] ext_int_n,
  input  logic [NINT-1:0] ext_lvl_en,
  input  logic            irq_pend,
  input  logic            idle_set,
  input  logic            pd_set,
  output logic            core_run,
  output logic            osc_en,
  output logic            sfr_clr,
  output logic            strobe_hold_hi,
  output logic            strobe_hold_lo,
  output logic            weak_pull,
  output logic            bus_float,
  output logic            idle_bit,
  output logic            pd_bit
);
  localparam int RST_CYC = MC_CLKS * RST_MC;

  pmu_state_e state_q, state_d;
  logic idle_q, idle_d, pd_q, pd_d, clr_q;
  logic stab_done, accept, arm, wake_int, osc_w;

  assign wake_int = |(~ext_int_n & ext_lvl_en);
  assign osc_w    = (state_q != S_PDSTOP);

  pmu_stab_cnt #(.STAB_CYC(STAB_CYC)) u_stab (
    .clk(clk), .arst_n(arst_n), .osc_en_i(osc_w), .done_o(stab_done));

  pmu_rst_qual #(.RST_CYC(RST_CYC)) u_qual (
    .clk(clk), .arst_n(arst_n), .rst_pin_i(rst_pin),
    .osc_ok_i(osc_w && stab_done), .accept_o(accept));

  pmu_test_arm u_arm (
    .clk(clk), .arst_n(arst_n), .in_rst_i(state_q == S_RST),
    .rst_pin_i(rst_pin), .ale_i(ale_pin), .psen_i(psen_pin), .arm_o(arm));

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_RST:    if (!rst_pin && stab_done) state_d = (arm && !ale_pin) ? S_TEST : S_RUN;
      S_RUN:    if (pd_q) state_d = S_PDSTOP;
                else if (idle_q) state_d = S_IDLE;
      S_IDLE:   if (irq_pend) state_d = S_RUN;
      S_PDSTOP: if (wake_int || rst_pin) state_d = S_PDWAKE;
      S_PDWAKE: if (!wake_int && !rst_pin) state_d = stab_done ? S_RUN : S_PDSTOP;
      S_TEST:   state_d = S_TEST;
      default:  state_d = S_RST;
    endcase
    if (accept) state_d = S_RST;
  end

  // request bits
  always_comb begin
    idle_d = idle_q;
    pd_d   = pd_q;
    if (state_q == S_RUN) begin
      idle_d = idle_q | idle_set;
      pd_d   = pd_q | pd_set;
      if (pd_q) idle_d = 1'b0;
    end
    if (state_q == S_IDLE   && state_d == S_RUN) idle_d = 1'b0;
    if (state_q == S_PDWAKE && state_d == S_RUN) pd_d   = 1'b0;
    if (accept) begin
      idle_d = 1'b0;
      pd_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q <= S_RST;
      idle_q  <= 1'b0;
      pd_q    <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idle_q  <= idle_d;
      pd_q    <= pd_d;
      clr_q   <= accept;
    end
  end

  assign core_run       = (state_q == S_RUN);
  assign osc_en         = osc_w;
  assign sfr_clr        = clr_q;
  assign strobe_hold_hi = (state_q == S_IDLE);
  assign strobe_hold_lo = (state_q == S_PDSTOP) || (state_q == S_PDWAKE);
  assign weak_pull      = (state_q == S_TEST);
  assign bus_float      = (state_q == S_TEST);
  assign idle_bit       = idle_q;
  assign pd_bit         = pd_q;

  p_osc_stop_needs_pd_r7: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(osc_en) |-> pd_bit);
  p_test_sticky_r4: assert property (@(posedge clk) disable iff (!arst_n)
    bus_float |=> (bus_float || sfr_clr));
  p_wake_after_stab_r9: assert property (@(posedge clk) disable iff (!arst_n)
    (core_run && $past(strobe_hold_lo)) |-> $past(stab_done));
  p_pd_exit_no_clr_r8: assert property (@(posedge clk) disable iff (!arst_n)
    (core_run && $past(strobe_hold_lo)) |-> !sfr_clr);
  p_idle_bit_drop_r6: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(idle_bit) |-> (core_run || sfr_clr || !osc_en));
endmodule

// File: tb/pmu_seq_bench.sv
module pmu_seq_bench;
  localparam int RST_CYC  = 24;
  localparam int STAB_CYC = 64;

  logic clk = 1'b0;
  logic arst_n, rst_pin, ale_pin, psen_pin, irq_pend, idle_set, pd_set;
  logic [1:0] ext_int_n, ext_lvl_en;
  logic core_run, osc_en, sfr_clr, strobe_hold_hi, strobe_hold_lo;
  logic weak_pull, bus_float, idle_bit, pd_bit;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pmu_seq u_pmu_seq (
    .clk(clk), .arst_n(arst_n), .rst_pin(rst_pin), .ale_pin(ale_pin),
    .psen_pin(psen_pin), .ext_int_n(ext_int_n), .ext_lvl_en(ext_lvl_en),
    .irq_pend(irq_pend), .idle_set(idle_set), .pd_set(pd_set),
    .core_run(core_run), .osc_en(osc_en), .sfr_clr(sfr_clr),
    .strobe_hold_hi(strobe_hold_hi), .strobe_hold_lo(strobe_hold_lo),
    .weak_pull(weak_pull), .bus_float(bus_float),
    .idle_bit(idle_bit), .pd_bit(pd_bit));

  function automatic int exp_pulses(input int len);
    return (len >= RST_CYC) ? 1 : 0;
  endfunction

  function automatic bit exp_wake_done(input int low_edges);
    return low_edges >= STAB_CYC + 1;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_rst(input int len, output int pulses);
    pulses = 0;
    rst_pin = 1'b1;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      pulses += int'(sfr_clr);
    end
    rst_pin = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      pulses += int'(sfr_clr);
    end
  endtask

  task automatic enter_pd();
    pd_set = 1'b1;
    cyc(1);
    pd_set = 1'b0;
    cyc(3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int p;
    void'($urandom(32'd4711));
    arst_n = 0; rst_pin = 1; ale_pin = 1; psen_pin = 1;
    ext_int_n = '1; ext_lvl_en = '0; irq_pend = 0; idle_set = 0; pd_set = 0;
    cyc(3);
    chk("R2", "core_run in reset", int'(core_run), 0);
    chk("R2", "osc_en in reset", int'(osc_en), 1);
    chk("R2", "bus_float in reset", int'(bus_float), 0);
    chk("R2", "sfr_clr in reset", int'(sfr_clr), 0);
    arst_n = 1;
    p = 0;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      p += int'(sfr_clr);
    end
    chk("R1", "power-up clear pulses", p, 1);
    rst_pin = 0;
    cyc(1);
    chk("R2", "run after release", int'(core_run), 1);

    // R1 reset width boundaries, directed then random
    pulse_rst(RST_CYC - 1, p);
    chk("R1", "pulses for width 23", p, 0);
    pulse_rst(RST_CYC, p);
    chk("R1", "pulses for width 24", p, 1);
    chk("R2", "run after accepted reset", int'(core_run), 1);
    for (int k = 0; k < 12; k++) begin
      int len;
      len = 18 + int'($urandom % 12);
      pulse_rst(len, p);
      chk("R1", $sformatf("pulses for width %0d", len), p, exp_pulses(len));
      chk("R2", "run after pulse", int'(core_run), 1);
    end

    // R3 test mode entry
    rst_pin = 1; ale_pin = 0; psen_pin = 1;
    cyc(30);
    rst_pin = 0;
    cyc(2);
    chk("R3", "bus_float in test", int'(bus_float), 1);
    chk("R3", "weak_pull in test", int'(weak_pull), 1);
    chk("R3", "core_run in test", int'(core_run), 0);
    ale_pin = 1;
    idle_set = 1; cyc(1); idle_set = 0;
    pd_set = 1; cyc(1); pd_set = 0;
    cyc(5);
    chk("R4", "still in test", int'(bus_float), 1);
    chk("R4", "osc in test", int'(osc_en), 1);
    chk("R4", "idle_bit ignored", int'(idle_bit), 0);
    chk("R4", "pd_bit ignored", int'(pd_bit), 0);
    pulse_rst(RST_CYC, p);
    chk("R4", "test exit clear pulse", p, 1);
    chk("R4", "test left by reset", int'(bus_float), 0);
    chk("R4", "run after test exit", int'(core_run), 1);

    // R3 negative: PSEN low during reset
    rst_pin = 1; ale_pin = 0; psen_pin = 0;
    cyc(30);
    rst_pin = 0;
    cyc(2);
    chk("R3", "no test with psen low", int'(bus_float), 0);
    chk("R3", "run with psen low", int'(core_run), 1);
    // R3 negative: ALE high at release
    psen_pin = 1;
    rst_pin = 1; ale_pin = 0;
    cyc(30);
    rst_pin = 0; ale_pin = 1;
    cyc(2);
    chk("R3", "no test with ale high at release", int'(bus_float), 0);
    chk("R3", "run with ale high at release", int'(core_run), 1);

    // R5/R6 idle with random dwell
    for (int k = 0; k < 6; k++) begin
      int d;
      d = 1 + int'($urandom % 20);
      idle_set = 1; cyc(1); idle_set = 0;
      chk("R5", "idle bit set", int'(idle_bit), 1);
      chk("R5", "still running one cycle", int'(core_run), 1);
      cyc(1);
      chk("R6", "core halted in idle", int'(core_run), 0);
      chk("R6", "strobes high in idle", int'(strobe_hold_hi), 1);
      chk("R6", "osc runs in idle", int'(osc_en), 1);
      cyc(d);
      chk("R6", "idle holds without irq", int'(core_run), 0);
      irq_pend = 1; cyc(1); irq_pend = 0;
      chk("R6", "run after irq", int'(core_run), 1);
      chk("R6", "idle bit cleared", int'(idle_bit), 0);
      chk("R6", "strobe hold released", int'(strobe_hold_hi), 0);
    end

    // R7/R8 power-down, interrupt exit
    enter_pd();
    chk("R7", "osc stopped", int'(osc_en), 0);
    chk("R7", "strobes low", int'(strobe_hold_lo), 1);
    chk("R7", "core halted", int'(core_run), 0);
    chk("R7", "pd bit set", int'(pd_bit), 1);
    ext_int_n[0] = 0; ext_lvl_en = 2'b00;
    cyc(5);
    chk("R7", "disabled line ignored", int'(osc_en), 0);
    ext_lvl_en = 2'b01;
    cyc(1);
    chk("R8", "osc restarted", int'(osc_en), 1);
    chk("R8", "core still halted", int'(core_run), 0);
    cyc(99);
    chk("R8", "halted while pin low", int'(core_run), 0);
    chk("R8", "strobes still low", int'(strobe_hold_lo), 1);
    ext_int_n[0] = 1;
    cyc(1);
    chk("R8", "run after pin high", int'(core_run), 1);
    chk("R8", "pd bit cleared", int'(pd_bit), 0);
    chk("R8", "no clear strobe", int'(sfr_clr), 0);

    // R9 stabilisation window: random aborts, then boundaries
    for (int k = 0; k < 4; k++) begin
      int n;
      n = 1 + int'($urandom % 60);
      enter_pd();
      ext_int_n[1] = 0; ext_lvl_en = 2'b10;
      cyc(n);
      ext_int_n[1] = 1;
      cyc(1);
      chk("R9", $sformatf("wake after %0d edges", n), int'(core_run), int'(exp_wake_done(n)));
      chk("R9", "osc stops after abort", int'(osc_en), 0);
      ext_int_n[1] = 0;
      cyc(STAB_CYC + 5);
      ext_int_n[1] = 1;
      cyc(1);
      chk("R9", "recovery wake", int'(core_run), 1);
    end
    ext_lvl_en = 2'b01;
    enter_pd();
    ext_int_n[0] = 0;
    cyc(STAB_CYC);
    ext_int_n[0] = 1;
    cyc(1);
    chk("R9", "wake at STAB edges", int'(core_run), int'(exp_wake_done(STAB_CYC)));
    chk("R9", "osc off at STAB edges", int'(osc_en), 0);
    cyc(3);
    ext_int_n[0] = 0;
    cyc(STAB_CYC + 1);
    ext_int_n[0] = 1;
    cyc(1);
    chk("R9", "wake at STAB+1 edges", int'(core_run), int'(exp_wake_done(STAB_CYC + 1)));

    // R5 priority of power-down over idle
    idle_set = 1; pd_set = 1; cyc(1); idle_set = 0; pd_set = 0;
    cyc(1);
    chk("R5", "pd wins: osc off", int'(osc_en), 0);
    chk("R5", "idle bit discarded", int'(idle_bit), 0);
    chk("R5", "pd bit kept", int'(pd_bit), 1);
    ext_int_n[0] = 0; cyc(70); ext_int_n[0] = 1;
    cyc(1);
    chk("R5", "run after pd exit", int'(core_run), 1);
    cyc(3);
    chk("R5", "no idle afterwards", int'(core_run), 1);

    // R10 reset exit from power-down
    enter_pd();
    rst_pin = 1;
    p = 0;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      p += int'(sfr_clr);
    end
    chk("R10", "clear pulses from pd reset", p, 1);
    chk("R10", "pd bit cleared", int'(pd_bit), 0);
    chk("R10", "halted during reset", int'(core_run), 0);
    chk("R10", "osc running", int'(osc_en), 1);
    rst_pin = 0;
    cyc(1);
    chk("R10", "run after release", int'(core_run), 1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule